// File: doc/BRIEF.md
# Full-Bridge Chopping Current Controller

This block is the digital controller for a single H-bridge made of two half-bridges, A and B. Each half-bridge has a high-side (source) switch and a low-side (sink) switch. Two direction inputs select one of four modes: coast, forward drive, reverse drive or brake. The block turns the mode into four registered gate enables. It inserts a crossover dead time whenever a switch that could short a half-bridge is about to turn on.

While the bridge drives, a trip flag from an external current-sense comparator starts a fixed off-time chop. The active source switch turns off at once. After a dead time, the idle-side sink switch turns on, so the winding current recirculates through both low sides in slow decay. When the off-time runs out, that sink switch turns off again. After a second dead time, the diagonal drive comes back. The trip flag is ignored for a blanking window after every change of the gate outputs, which keeps switching transients from causing false trips.

A global disable input forces every gate off and discards any chop in progress. All timing is counted in system clock cycles and set by parameters. At 250 MHz the defaults give a 500 ns dead time, 3 us of blanking and a 25 us off-time.

Top module: `bridge_chop_ctrl`

## Requirements
- R1: With both direction inputs low, all four gate enables are low from the next clock edge on.
- R2: A change to a driving mode holds all four gates low for exactly DEAD_CYC cycles, then drives a diagonal pair. Inputs (dir_a=1, dir_b=0) drive src_a and snk_b. Inputs (dir_a=0, dir_b=1) drive src_b and snk_a.
- R3: With both direction inputs high, the block holds all four gates low for DEAD_CYC cycles and then turns on snk_a and snk_b with both sources off. A trip has no effect in this mode.
- R4: A trip sampled during drive, after blanking has ended, turns the active source off at the next edge. The sink of the driving diagonal stays on.
- R5: The sink on the same side as the source that was switched off turns on exactly DEAD_CYC cycles after that source turned off.
- R6: OFF_CYC cycles after the trip edge, the recirculation sink turns off. After a further DEAD_CYC cycles, the diagonal drive is restored.
- R7: A trip is ignored for BLANK_CYC cycles after every gate change, and this includes the restore after an off-time.
- R8: A trip held during the off-time does not change the length of the chop cycle.
- R9: A mode change during the off-time ends the chop. All gates go low at the next edge, and the new mode follows after DEAD_CYC cycles.
- R10: Asserting the disable input drives all gates low at the next edge and clears the chop state. On release, the block applies a dead time and then starts the current mode from the beginning.
- R11: The source and sink of the same half-bridge are never on together.
- R12: While reset is asserted, all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input, A side |
| dir_b | input | 1 | Direction input, B side |
| trip_i | input | 1 | Over-threshold flag from the current-sense comparator |
| disable_i | input | 1 | Global output disable |
| src_a | output | 1 | Gate enable, A-side source switch |
| src_b | output | 1 | Gate enable, B-side source switch |
| snk_a | output | 1 | Gate enable, A-side sink switch |
| snk_b | output | 1 | Gate enable, B-side sink switch |

## Verification
Two events can land in the same cycle. A comparator trip can arrive on the very cycle that a gate change restarts blanking, and a trip can be held through an off-time into the restore that ends it. The bench holds the trip high from the accepted trip, through the whole chop, and on for BLANK_CYC cycles after the diagonal comes back. It then checks three things: the off-time and both dead times keep their exact cycle counts, the restored drive survives the blanking window, and no second chop starts. A second pairing is a mode change that arrives during the off-time. For that case, the bench checks that the gates go low at the next edge and that the new diagonal appears after exactly one dead time.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        MD_COAST = 2'd0,
        MD_FWD   = 2'd1,
        MD_REV   = 2'd2,
        MD_BRAKE = 2'd3
    } bcc_mode_e;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_GAP     = 3'd1,
        ST_DRIVE   = 3'd2,
        ST_CHOPGAP = 3'd3,
        ST_CHOP    = 3'd4,
        ST_RESUME  = 3'd5,
        ST_BRAKE   = 3'd6
    } bcc_state_e;

    typedef struct packed {
        logic src_a;
        logic src_b;
        logic snk_a;
        logic snk_b;
    } bcc_gates_t;

    typedef struct packed {
        bcc_state_e state;
        bcc_mode_e  act;
        bcc_gates_t gates;
    } bcc_regs_t;

    // Gate pattern for a state; REV mirrors FWD across the two half-bridges.
    function automatic bcc_gates_t gates_for(bcc_state_e st, bcc_mode_e md);
        bcc_gates_t g;
        logic       rev;
        g   = '0;
        rev = (md == MD_REV);
        case (st)
            ST_DRIVE: begin
                g.src_a = !rev;
                g.snk_b = !rev;
                g.src_b = rev;
                g.snk_a = rev;
            end
            ST_CHOPGAP, ST_RESUME: begin
                g.snk_b = !rev;
                g.snk_a = rev;
            end
            ST_CHOP, ST_BRAKE: begin
                g.snk_a = 1'b1;
                g.snk_b = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
(
    input  logic      in_a,
    input  logic      in_b,
    output bcc_mode_e mode
);
    always_comb begin
        unique case ({in_a, in_b})
            2'b10:   mode = MD_FWD;
            2'b01:   mode = MD_REV;
            2'b11:   mode = MD_BRAKE;
            default: mode = MD_COAST;
        endcase
    end
endmodule

// File: rtl/bcc_downcnt.sv
module bcc_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R7
    load_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> busy);
endmodule

// File: rtl/bridge_chop_ctrl.sv
module bridge_chop_ctrl
    import bcc_pkg::*;
#(
    parameter int DEAD_CYC  = 125,
    parameter int BLANK_CYC = 750,
    parameter int OFF_CYC   = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a,
    input  logic dir_b,
    input  logic trip_i,
    input  logic disable_i,
    output logic src_a,
    output logic src_b,
    output logic snk_a,
    output logic snk_b
);
    localparam int MAXC = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] CHOP_LD = CW'(OFF_CYC - DEAD_CYC - 1);
    localparam logic [CW-1:0] BLNK_LD = CW'(BLANK_CYC);

    initial begin
        if (DEAD_CYC < 1 || OFF_CYC <= DEAD_CYC || BLANK_CYC < 1)
            $error("bridge_chop_ctrl: timing parameters out of range");
    end

    bcc_mode_e cmd;
    bcc_regs_t r_d, r_q;
    logic      ph_load;
    logic [CW-1:0] ph_val;
    logic      ph_busy;
    logic      blank_busy;
    logic      blank_load;
    logic      trip_ok;

    bcc_decode u_decode (
        .in_a (dir_a),
        .in_b (dir_b),
        .mode (cmd)
    );

    bcc_downcnt #(.W(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .busy     (ph_busy)
    );

    assign blank_load = (r_d.gates != r_q.gates);

    bcc_downcnt #(.W(CW)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (blank_load),
        .load_val (BLNK_LD),
        .busy     (blank_busy)
    );

    assign trip_ok = trip_i && !blank_busy;

    always_comb begin
        r_d     = r_q;
        ph_load = 1'b0;
        ph_val  = '0;
        if (disable_i) begin
            r_d.state = ST_OFF;
            r_d.act   = MD_COAST;
            ph_load   = 1'b1;
        end else if (cmd != r_q.act) begin
            r_d.act = cmd;
            ph_load = 1'b1;
            if (cmd == MD_COAST) begin
                r_d.state = ST_OFF;
            end else begin
                r_d.state = ST_GAP;
                ph_val    = DEAD_LD;
            end
        end else begin
            unique case (r_q.state)
                ST_GAP: if (!ph_busy)
                    r_d.state = (r_q.act == MD_BRAKE) ? ST_BRAKE : ST_DRIVE;
                ST_DRIVE: if (trip_ok) begin
                    r_d.state = ST_CHOPGAP;
                    ph_load   = 1'b1;
                    ph_val    = DEAD_LD;
                end
                ST_CHOPGAP: if (!ph_busy) begin
                    r_d.state = ST_CHOP;
                    ph_load   = 1'b1;
                    ph_val    = CHOP_LD;
                end
                ST_CHOP: if (!ph_busy) begin
                    r_d.state = ST_RESUME;
                    ph_load   = 1'b1;
                    ph_val    = DEAD_LD;
                end
                ST_RESUME: if (!ph_busy)
                    r_d.state = ST_DRIVE;
                default: r_d.state = r_q.state;
            endcase
        end
        r_d.gates = gates_for(r_d.state, r_d.act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_OFF, act: MD_COAST, gates: '0};
        else        r_q <= r_d;
    end

    assign src_a = r_q.gates.src_a;
    assign src_b = r_q.gates.src_b;
    assign snk_a = r_q.gates.snk_a;
    assign snk_b = r_q.gates.snk_b;

    // R11
    no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_a && snk_a));
    // R11
    no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_b && snk_b));
    // R5
    sink_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snk_a) |-> !$past(src_a));
    // R5
    sink_b_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snk_b) |-> !$past(src_b));
    // R2
    src_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_a) |-> !$past(snk_a));
    // R2
    src_b_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_b) |-> !$past(snk_b));
    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> !(src_a || src_b || snk_a || snk_b));
    // R1
    coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_a && !dir_b) |=> !(src_a || src_b || snk_a || snk_b));
    // R7
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DRIVE && blank_busy) |=> r_q.state != ST_CHOPGAP);
endmodule

// File: tb/bridge_chop_ctrl_bench.sv
module bridge_chop_ctrl_bench;
    localparam int DEAD  = 4;
    localparam int BLANK = 10;
    localparam int OFF   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 1'b0, dir_b = 1'b0, trip_i = 1'b0, disable_i = 1'b0;
    logic src_a, src_b, snk_a, snk_b;
    int   n_chk = 0, n_bad = 0, shoot_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    bridge_chop_ctrl #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .OFF_CYC(OFF)) u_bridge_chop_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
        .trip_i(trip_i), .disable_i(disable_i),
        .src_a(src_a), .src_b(src_b), .snk_a(snk_a), .snk_b(snk_b)
    );

    // gate vector order: {src_a, src_b, snk_a, snk_b}
    localparam logic [5:0] VEC [4] = '{
        {2'b00, 4'b0000},
        {2'b10, 4'b1001},
        {2'b01, 4'b0110},
        {2'b11, 4'b0011}
    };

    always @(negedge clk) begin
        if (rst_n && ((src_a && snk_a) || (src_b && snk_b))) shoot_bad++;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {src_a, src_b, snk_a, snk_b};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: gates got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(3);
        chk("R12 reset", 4'b0000);
        rst_n = 1'b1;
        tick(2);

        // truth table walk (R1 R2 R3)
        for (int i = 0; i < 4; i++) begin
            {dir_a, dir_b} = VEC[i][5:4];
            tick(DEAD);
            chk("R2 dead gap", 4'b0000);
            tick(1);
            chk("R2 R3 mode pattern", VEC[i][3:0]);
            {dir_a, dir_b} = 2'b00;
            tick(1);
            chk("R1 coast", 4'b0000);
        end

        // forward chop with trip held throughout (R4 R5 R6 R7 R8)
        {dir_a, dir_b} = 2'b10;
        tick(DEAD + 1);
        chk("R2 fwd drive", 4'b1001);
        trip_i = 1'b1;
        tick(BLANK);
        chk("R7 blank after drive start", 4'b1001);
        tick(1);
        chk("R4 trip source off", 4'b0001);
        tick(DEAD - 1);
        chk("R5 sr sink still off", 4'b0001);
        tick(1);
        chk("R5 sr sink on", 4'b0011);
        tick(OFF - DEAD - 1);
        chk("R8 chop holds under trip", 4'b0011);
        tick(1);
        chk("R6 off-time end", 4'b0001);
        tick(DEAD - 1);
        chk("R6 resume gap", 4'b0001);
        tick(1);
        chk("R6 drive restored", 4'b1001);
        tick(BLANK);
        chk("R7 blank after restore", 4'b1001);
        trip_i = 1'b0;
        tick(1);
        chk("R7 still driving", 4'b1001);

        // reverse chop, then abort by mode change (R2 R5 R9)
        {dir_a, dir_b} = 2'b01;
        tick(1);
        chk("R9 mode change gap", 4'b0000);
        tick(DEAD - 1);
        chk("R2 rev gap", 4'b0000);
        tick(1);
        chk("R2 rev drive", 4'b0110);
        trip_i = 1'b1;
        tick(BLANK + 1);
        chk("R4 rev trip", 4'b0010);
        trip_i = 1'b0;
        tick(DEAD);
        chk("R5 rev sr sink", 4'b0011);
        {dir_a, dir_b} = 2'b10;
        tick(1);
        chk("R9 abort all off", 4'b0000);
        tick(DEAD - 1);
        chk("R9 abort gap", 4'b0000);
        tick(1);
        chk("R9 new mode", 4'b1001);

        // brake ignores trip (R3)
        {dir_a, dir_b} = 2'b11;
        tick(DEAD + 1);
        chk("R3 brake", 4'b0011);
        trip_i = 1'b1;
        tick(BLANK + 20);
        chk("R3 brake trip ignored", 4'b0011);
        trip_i = 1'b0;

        // disable (R10)
        {dir_a, dir_b} = 2'b10;
        tick(DEAD + 1);
        chk("R10 pre drive", 4'b1001);
        disable_i = 1'b1;
        tick(1);
        chk("R10 disable off", 4'b0000);
        tick(5);
        chk("R10 disable held", 4'b0000);
        disable_i = 1'b0;
        tick(DEAD);
        chk("R10 release gap", 4'b0000);
        tick(1);
        chk("R10 release drive", 4'b1001);
        trip_i = 1'b1;
        tick(BLANK + 1);
        chk("R4 chop before disable", 4'b0001);
        trip_i = 1'b0;
        disable_i = 1'b1;
        tick(1);
        chk("R10 disable in chop", 4'b0000);
        disable_i = 1'b0;
        tick(DEAD + 1);
        chk("R10 chop cleared", 4'b1001);

        // coast from drive, then reset mid drive (R1 R12)
        {dir_a, dir_b} = 2'b00;
        tick(1);
        chk("R1 coast from drive", 4'b0000);
        {dir_a, dir_b} = 2'b10;
        tick(DEAD + 1);
        chk("R2 drive before reset", 4'b1001);
        rst_n = 1'b0;
        tick(1);
        chk("R12 reset mid drive", 4'b0000);

        n_chk++;
        if (shoot_bad != 0) begin
            n_bad++;
            $display("FAIL R11: shoot-through cycles got %0d expected 0", shoot_bad);
        end
        done = 1'b1;
        finish_run();
    end
endmodule